// File: doc/BRIEF.md
# Width-Limited Reorder-Buffer Head Retirement Controller

This block decides, each cycle, which of the oldest reorder-buffer entries of one granted thread leave the buffer. The buffer shows the controller its `CW` oldest entries as parallel slot descriptors, with slot 0 the oldest. The controller scans them in age order. It retires executed entries as commits and drops squashed entries without counting them. It stops at the first entry that cannot leave this cycle.

An entry at the head that was never executed does not retire. The same holds for an entry that carries a fault. Either kind is acted on only when it would be the first commit of the cycle and the granted thread has no store waiting for writeback. An unexecuted entry then turns into a non-speculative issue request. A faulting entry starts a trap. The trap holds the trap state machine in `ST_TRAP_WAIT` for `TRAP_LAT` cycles and then raises a squash pulse.

Registered per-thread reports go back to earlier pipeline stages. They cover free-entry changes, an "empty" notice, and the sequence number of the last committed entry. A saturation counter records cycles in which the full width was used.

The trap state machine has two states. `ST_RUN` is normal scanning. `ST_TRAP_WAIT` blocks all retirement while the trap countdown runs. The transition `ST_RUN -> ST_TRAP_WAIT` is taken on a trap start. The transition `ST_TRAP_WAIT -> ST_RUN` is taken in the cycle that carries the squash pulse.

Top module: `retire_ctrl`

## Requirements
- R1: Slots retire strictly oldest-first as a contiguous run from slot 0, at most `CW` per cycle. The scan halts at the first slot whose valid or ready bit is low. Nothing retires when `grant_vld` is low.
- R2: A valid, ready, squashed slot is set in `retire_mask` and clear in `commit_mask`. It does not count as a commit for the first-commit rule of R3 and R4.
- R3: A valid, ready, unexecuted slot halts the scan and never retires. If no commit came before it this cycle and `st_pend[grant_tid]` is 0, `ns_req` is 1, `ns_seq` is its sequence number and `ns_unc` is its uncached bit. Otherwise `ns_req` is 0.
- R4: A valid, ready, executed, faulting slot halts the scan and never retires. It pulses `trap_start` under the same first-commit and no-pending-store condition as R3.
- R5: After `trap_start` in cycle c, `trap_pend` is 1 in cycles c+1 through c+`TRAP_LAT`. `trap_squash` is 1 only in cycle c+`TRAP_LAT`, and `trap_tid` holds the thread that faulted. No slot retires while `trap_pend` is 1.
- R6: `commit_cnt` equals the number of bits set in `commit_mask`. `done_seq` is the sequence number of the youngest committed slot. In the next cycle, `last_seq` of the granted thread holds that number.
- R7: In the next cycle, `empty_rpt[t]` is 1 exactly when `rob_empty[t]` was 1, `st_pend[t]` was 0, and no store of thread t committed.
- R8: In the next cycle, `free_upd[t]` is 1 exactly when `ins_vld[t]` was 1 or any slot of thread t retired.
- R9: `full_cnt` increments, wrapping, in every cycle where `commit_cnt` equals `CW`.
- R10: During reset, `trap_pend`, `trap_squash`, `empty_rpt`, `free_upd`, `last_seq` and `full_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_vld | input | 1 | A thread is granted for retirement this cycle |
| grant_tid | input | TID_W | Granted thread |
| slot_vld | input | CW | Slot holds an entry |
| slot_rdy | input | CW | Entry is ready to leave |
| slot_sq | input | CW | Entry was squashed |
| slot_exe | input | CW | Entry has executed |
| slot_flt | input | CW | Entry carries a fault |
| slot_st | input | CW | Entry is a store |
| slot_unc | input | CW | Entry is an uncached load |
| slot_seq | input | CW*SEQ_W | Sequence numbers, slot k at bits k*SEQ_W |
| st_pend | input | NT | Per thread: stores awaiting writeback |
| rob_empty | input | NT | Per thread: buffer holds no entries |
| ins_vld | input | NT | Per thread: entries inserted this cycle |
| retire_mask | output | CW | Slots removed this cycle |
| commit_mask | output | CW | Slots committed this cycle |
| commit_cnt | output | $clog2(CW+1) | Number of commits this cycle |
| done_vld | output | 1 | At least one commit this cycle |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| ns_req | output | 1 | Non-speculative issue request |
| ns_seq | output | SEQ_W | Sequence number of the request |
| ns_unc | output | 1 | Request is an uncached load |
| trap_start | output | 1 | Faulting head accepted, trap begins |
| trap_pend | output | 1 | Trap countdown in progress |
| trap_squash | output | 1 | Trap squash pulse |
| trap_tid | output | TID_W | Thread of the trap |
| empty_rpt | output | NT | Registered empty notice per thread |
| free_upd | output | NT | Registered free-entry update per thread |
| last_seq | output | NT*SEQ_W | Last committed sequence number per thread |
| full_cnt | output | FC_W | Count of full-width cycles |

## Verification
The bench targets a squashed slot 0 in front of an unexecuted or faulting slot 1. A design that counted the squash as a commit would miss the request or the trap there. It also covers an unexecuted or faulting slot behind a real commit, and a head that waits on pending stores. A design that ignored the first-commit rule would issue early in those cases, letting a non-speculative operation or trap overtake older work. The trap countdown is timed to the exact cycle. Commits presented during the countdown must stay blocked, or entries would retire past a faulting instruction. A store commit is paired with an empty buffer to show that the empty notice is withheld. A design that missed this would release earlier stages before the store reached memory.

// File: rtl/retire_pkg.sv
package retire_pkg;

    typedef enum logic [0:0] {
        ST_RUN       = 1'b0,
        ST_TRAP_WAIT = 1'b1
    } trap_state_e;

    typedef struct packed {
        logic vld;
        logic rdy;
        logic sq;
        logic exe;
        logic flt;
        logic st;
        logic unc;
    } slot_flags_t;

endpackage

// File: rtl/retire_scan.sv
module retire_scan
    import retire_pkg::*;
#(
    parameter int CW     = 2,
    parameter int SEQ_W  = 16,
    parameter int CNT_NW = $clog2(CW + 1)
) (
    input  logic                    enable,
    input  logic                    stores_busy,
    input  slot_flags_t             flags [CW],
    input  logic [SEQ_W-1:0]        seqs  [CW],
    output logic [CW-1:0]           retire_mask,
    output logic [CW-1:0]           commit_mask,
    output logic [CNT_NW-1:0]       commit_cnt,
    output logic                    store_commit,
    output logic                    done_vld,
    output logic [SEQ_W-1:0]        done_seq,
    output logic                    ns_req,
    output logic [SEQ_W-1:0]        ns_seq,
    output logic                    ns_unc,
    output logic                    flt_take
);

    logic              halt;
    logic [CNT_NW-1:0] ncom;

    always_comb begin
        retire_mask  = '0;
        commit_mask  = '0;
        ncom         = '0;
        halt         = !enable;
        store_commit = 1'b0;
        done_vld     = 1'b0;
        done_seq     = '0;
        ns_req       = 1'b0;
        ns_seq       = '0;
        ns_unc       = 1'b0;
        flt_take     = 1'b0;
        for (int k = 0; k < CW; k++) begin
            if (!halt) begin
                if (!flags[k].vld || !flags[k].rdy) begin
                    halt = 1'b1;
                end else if (flags[k].sq) begin
                    retire_mask[k] = 1'b1;
                end else if (!flags[k].exe || flags[k].flt) begin
                    halt = 1'b1;
                    if (ncom == '0 && !stores_busy) begin
                        if (!flags[k].exe) begin
                            ns_req = 1'b1;
                            ns_seq = seqs[k];
                            ns_unc = flags[k].unc;
                        end else begin
                            flt_take = 1'b1;
                        end
                    end
                end else begin
                    retire_mask[k] = 1'b1;
                    commit_mask[k] = 1'b1;
                    ncom           = ncom + CNT_NW'(1);
                    done_vld       = 1'b1;
                    done_seq       = seqs[k];
                    if (flags[k].st) store_commit = 1'b1;
                end
            end
        end
        commit_cnt = ncom;
    end

endmodule

// File: rtl/trap_timer.sv
module trap_timer
    import retire_pkg::*;
#(
    parameter int TRAP_LAT = 3,
    parameter int TID_W    = 1,
    parameter int LAT_W    = $clog2(TRAP_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TID_W-1:0] start_tid,
    output logic             pend,
    output logic             squash,
    output logic [TID_W-1:0] tid
);

    trap_state_e      state_q, state_d;
    logic [LAT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (start) state_d = ST_TRAP_WAIT;
            ST_TRAP_WAIT: if (cnt_q == '0) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            tid     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && start) begin
                cnt_q <= LAT_W'(TRAP_LAT - 1);
                tid   <= start_tid;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - LAT_W'(1);
            end
        end
    end

    always_comb begin
        pend   = (state_q == ST_TRAP_WAIT);
        squash = (state_q == ST_TRAP_WAIT) && (cnt_q == '0);
    end

endmodule

// File: rtl/retire_track.sv
module retire_track #(
    parameter int NT    = 2,
    parameter int TID_W = 1,
    parameter int SEQ_W = 16,
    parameter int FC_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grant_vld,
    input  logic [TID_W-1:0]      grant_tid,
    input  logic                  any_retire,
    input  logic                  done_vld,
    input  logic [SEQ_W-1:0]      done_seq,
    input  logic                  store_commit,
    input  logic                  full_cycle,
    input  logic [NT-1:0]         rob_empty,
    input  logic [NT-1:0]         st_pend,
    input  logic [NT-1:0]         ins_vld,
    output logic [NT-1:0]         empty_rpt,
    output logic [NT-1:0]         free_upd,
    output logic [NT*SEQ_W-1:0]   last_seq,
    output logic [FC_W-1:0]       full_cnt
);

    for (genvar g = 0; g < NT; g++) begin : g_thr
        logic sel;
        assign sel = grant_vld && (grant_tid == TID_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                empty_rpt[g]                 <= 1'b0;
                free_upd[g]                  <= 1'b0;
                last_seq[g*SEQ_W +: SEQ_W]   <= '0;
            end else begin
                empty_rpt[g] <= rob_empty[g] && !st_pend[g] && !(sel && store_commit);
                free_upd[g]  <= ins_vld[g] || (sel && any_retire);
                if (sel && done_vld) last_seq[g*SEQ_W +: SEQ_W] <= done_seq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          full_cnt <= '0;
        else if (full_cycle) full_cnt <= full_cnt + FC_W'(1);
    end

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
    import retire_pkg::*;
#(
    parameter int CW       = 2,
    parameter int NT       = 2,
    parameter int SEQ_W    = 16,
    parameter int TRAP_LAT = 3,
    parameter int FC_W     = 16,
    parameter int TID_W    = (NT > 1) ? $clog2(NT) : 1,
    parameter int CNT_NW   = $clog2(CW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grant_vld,
    input  logic [TID_W-1:0]      grant_tid,
    input  logic [CW-1:0]         slot_vld,
    input  logic [CW-1:0]         slot_rdy,
    input  logic [CW-1:0]         slot_sq,
    input  logic [CW-1:0]         slot_exe,
    input  logic [CW-1:0]         slot_flt,
    input  logic [CW-1:0]         slot_st,
    input  logic [CW-1:0]         slot_unc,
    input  logic [CW*SEQ_W-1:0]   slot_seq,
    input  logic [NT-1:0]         st_pend,
    input  logic [NT-1:0]         rob_empty,
    input  logic [NT-1:0]         ins_vld,
    output logic [CW-1:0]         retire_mask,
    output logic [CW-1:0]         commit_mask,
    output logic [CNT_NW-1:0]     commit_cnt,
    output logic                  done_vld,
    output logic [SEQ_W-1:0]      done_seq,
    output logic                  ns_req,
    output logic [SEQ_W-1:0]      ns_seq,
    output logic                  ns_unc,
    output logic                  trap_start,
    output logic                  trap_pend,
    output logic                  trap_squash,
    output logic [TID_W-1:0]      trap_tid,
    output logic [NT-1:0]         empty_rpt,
    output logic [NT-1:0]         free_upd,
    output logic [NT*SEQ_W-1:0]   last_seq,
    output logic [FC_W-1:0]       full_cnt
);

    slot_flags_t      flags [CW];
    logic [SEQ_W-1:0] seqs  [CW];
    logic             store_commit;
    logic             scan_en;

    for (genvar k = 0; k < CW; k++) begin : g_slot
        assign flags[k] = '{vld: slot_vld[k], rdy: slot_rdy[k], sq: slot_sq[k],
                            exe: slot_exe[k], flt: slot_flt[k], st: slot_st[k],
                            unc: slot_unc[k]};
        assign seqs[k]  = slot_seq[k*SEQ_W +: SEQ_W];
    end

    assign scan_en = grant_vld && !trap_pend;

    retire_scan #(.CW(CW), .SEQ_W(SEQ_W), .CNT_NW(CNT_NW)) u_scan (
        .enable       (scan_en),
        .stores_busy  (st_pend[grant_tid]),
        .flags        (flags),
        .seqs         (seqs),
        .retire_mask  (retire_mask),
        .commit_mask  (commit_mask),
        .commit_cnt   (commit_cnt),
        .store_commit (store_commit),
        .done_vld     (done_vld),
        .done_seq     (done_seq),
        .ns_req       (ns_req),
        .ns_seq       (ns_seq),
        .ns_unc       (ns_unc),
        .flt_take     (trap_start)
    );

    trap_timer #(.TRAP_LAT(TRAP_LAT), .TID_W(TID_W)) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (trap_start),
        .start_tid (grant_tid),
        .pend      (trap_pend),
        .squash    (trap_squash),
        .tid       (trap_tid)
    );

    retire_track #(.NT(NT), .TID_W(TID_W), .SEQ_W(SEQ_W), .FC_W(FC_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_vld    (grant_vld),
        .grant_tid    (grant_tid),
        .any_retire   (|retire_mask),
        .done_vld     (done_vld),
        .done_seq     (done_seq),
        .store_commit (store_commit),
        .full_cycle   (commit_cnt == CNT_NW'(CW)),
        .rob_empty    (rob_empty),
        .st_pend      (st_pend),
        .ins_vld      (ins_vld),
        .empty_rpt    (empty_rpt),
        .free_upd     (free_upd),
        .last_seq     (last_seq),
        .full_cnt     (full_cnt)
    );

endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
    parameter int CW     = 2,
    parameter int FC_W   = 16,
    parameter int CNT_NW = $clog2(CW + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     retire_mask,
    input logic [CW-1:0]     commit_mask,
    input logic [CNT_NW-1:0] commit_cnt,
    input logic              ns_req,
    input logic              trap_start,
    input logic              trap_pend,
    input logic              trap_squash,
    input logic [FC_W-1:0]   full_cnt
);

    // R1: retired slots form a run starting at slot 0
    a_r1_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((retire_mask + CW'(1)) & retire_mask) == '0);

    // R2: every committed slot is also removed
    a_r2_commit_in_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_mask & ~retire_mask) == '0);

    // R3: a non-speculative request only when nothing committed this cycle
    a_r3_ns_first: assert property (@(posedge clk) disable iff (!rst_n)
        ns_req |-> (commit_cnt == '0 && !trap_start));

    // R4: a trap start only when nothing committed this cycle
    a_r4_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
        trap_start |-> commit_cnt == '0);

    // R5: trap start leads into the pending window
    a_r5_trap_enter: assert property (@(posedge clk) disable iff (!rst_n)
        trap_start |=> trap_pend);

    // R5: nothing leaves while the trap is pending
    a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pend |-> (retire_mask == '0 && !trap_start));

    // R5: squash pulse closes the window
    a_r5_squash_exit: assert property (@(posedge clk) disable iff (!rst_n)
        trap_squash |=> !trap_pend);

    // R9: full-width cycles advance the counter
    a_r9_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_cnt == CNT_NW'(CW)) |=> full_cnt == FC_W'($past(full_cnt) + FC_W'(1)));

endmodule

bind retire_ctrl retire_ctrl_chk #(.CW(CW), .FC_W(FC_W)) u_chk (.*);

// File: tb/retire_ctrl_tb.sv
module retire_ctrl_tb;

    localparam int CW       = 2;
    localparam int NT       = 2;
    localparam int SEQ_W    = 16;
    localparam int TRAP_LAT = 3;
    localparam int FC_W     = 16;
    localparam int TID_W    = 1;
    localparam int CLK_PER  = 10;
    localparam int NVEC     = 13;

    // flag code per slot: {vld, rdy, sq, exe, flt, st, unc}
    // vector: {s0[7], s1[7], stp, ret[2], com[2], ns, unc, trap}
    localparam logic [21:0] VEC [NVEC] = '{
        {7'h68, 7'h68, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0},
        {7'h68, 7'h48, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0},
        {7'h00, 7'h68, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
        {7'h70, 7'h68, 1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0},
        {7'h70, 7'h70, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0},
        {7'h60, 7'h68, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0},
        {7'h60, 7'h68, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
        {7'h68, 7'h60, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0},
        {7'h70, 7'h60, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0},
        {7'h61, 7'h68, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0},
        {7'h6C, 7'h68, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
        {7'h68, 7'h6C, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0},
        {7'h6A, 7'h68, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 grant_vld;
    logic [TID_W-1:0]     grant_tid;
    logic [CW-1:0]        slot_vld, slot_rdy, slot_sq, slot_exe, slot_flt, slot_st, slot_unc;
    logic [CW*SEQ_W-1:0]  slot_seq;
    logic [NT-1:0]        st_pend, rob_empty, ins_vld;
    logic [CW-1:0]        retire_mask, commit_mask;
    logic [1:0]           commit_cnt;
    logic                 done_vld;
    logic [SEQ_W-1:0]     done_seq, ns_seq;
    logic                 ns_req, ns_unc, trap_start, trap_pend, trap_squash;
    logic [TID_W-1:0]     trap_tid;
    logic [NT-1:0]        empty_rpt, free_upd;
    logic [NT*SEQ_W-1:0]  last_seq;
    logic [FC_W-1:0]      full_cnt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER / 2) clk = ~clk;

    retire_ctrl #(.CW(CW), .NT(NT), .SEQ_W(SEQ_W), .TRAP_LAT(TRAP_LAT), .FC_W(FC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_tid(grant_tid),
        .slot_vld(slot_vld), .slot_rdy(slot_rdy), .slot_sq(slot_sq), .slot_exe(slot_exe),
        .slot_flt(slot_flt), .slot_st(slot_st), .slot_unc(slot_unc), .slot_seq(slot_seq),
        .st_pend(st_pend), .rob_empty(rob_empty), .ins_vld(ins_vld),
        .retire_mask(retire_mask), .commit_mask(commit_mask), .commit_cnt(commit_cnt),
        .done_vld(done_vld), .done_seq(done_seq), .ns_req(ns_req), .ns_seq(ns_seq),
        .ns_unc(ns_unc), .trap_start(trap_start), .trap_pend(trap_pend),
        .trap_squash(trap_squash), .trap_tid(trap_tid), .empty_rpt(empty_rpt),
        .free_upd(free_upd), .last_seq(last_seq), .full_cnt(full_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_slots(input logic [6:0] a, input logic [6:0] b,
                             input logic [SEQ_W-1:0] sa, input logic [SEQ_W-1:0] sb);
        {slot_vld[0], slot_rdy[0], slot_sq[0], slot_exe[0], slot_flt[0], slot_st[0], slot_unc[0]} = a;
        {slot_vld[1], slot_rdy[1], slot_sq[1], slot_exe[1], slot_flt[1], slot_st[1], slot_unc[1]} = b;
        slot_seq = {sb, sa};
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; grant_vld = 1'b0; grant_tid = '0;
        st_pend = '0; rob_empty = '0; ins_vld = '0;
        put_slots(7'h00, 7'h00, '0, '0);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 trap_pend", 32'(trap_pend), 0);
        chk("R10 trap_squash", 32'(trap_squash), 0);
        chk("R10 full_cnt", 32'(full_cnt), 0);
        chk("R10 empty_rpt", 32'(empty_rpt), 0);
        chk("R10 free_upd", 32'(free_upd), 0);
        chk("R10 last_seq", 32'(last_seq), 0);
        rst_n = 1'b1;

        // table walk: thread 0 granted, slot seqs 100+2i / 101+2i
        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            logic [SEQ_W-1:0] sa, sb;
            @(negedge clk);
            v  = VEC[i];
            sa = SEQ_W'(100 + 2 * i);
            sb = SEQ_W'(101 + 2 * i);
            grant_vld = 1'b1; grant_tid = 1'b0;
            st_pend   = {1'b0, v[7]};
            put_slots(v[21:15], v[14:8], sa, sb);
            #2;
            chk($sformatf("R1/R2 retire_mask vec%0d", i), 32'(retire_mask), 32'(v[6:5]));
            chk($sformatf("R2 commit_mask vec%0d", i), 32'(commit_mask), 32'(v[4:3]));
            chk($sformatf("R6 commit_cnt vec%0d", i), 32'(commit_cnt), 32'(v[4] + v[3]));
            chk($sformatf("R3 ns_req vec%0d", i), 32'(ns_req), 32'(v[2]));
            chk($sformatf("R3 ns_unc vec%0d", i), 32'(ns_unc), 32'(v[1]));
            chk($sformatf("R4 trap_start vec%0d", i), 32'(trap_start), 32'(v[0]));
            if (v[2])
                chk($sformatf("R3 ns_seq vec%0d", i), 32'(ns_seq), 32'(v[5] ? sb : sa));
            if (v[4:3] != 2'b00)
                chk($sformatf("R6 done_seq vec%0d", i), 32'(done_seq), 32'(v[4] ? sb : sa));
        end

        @(negedge clk);
        chk("R6 last_seq thread0", 32'(last_seq[0 +: SEQ_W]), 125);
        chk("R9 full_cnt after table", 32'(full_cnt), 2);

        // R1: no grant, nothing leaves
        grant_vld = 1'b0; st_pend = '0;
        put_slots(7'h68, 7'h68, 16'd300, 16'd301);
        #2;
        chk("R1 no grant retire", 32'(retire_mask), 0);

        // R6/R8: thread 1 commit
        @(negedge clk);
        grant_vld = 1'b1; grant_tid = 1'b1;
        put_slots(7'h68, 7'h48, 16'd500, 16'd501);
        #2;
        chk("R1 thread1 commit", 32'(commit_mask), 1);
        @(negedge clk);
        #1;
        chk("R6 last_seq thread1", 32'(last_seq[SEQ_W +: SEQ_W]), 500);
        chk("R8 free_upd after thread1 retire", 32'(free_upd), 2);

        // R7/R8: store commit on thread 0 with both buffers empty
        grant_tid = 1'b0; rob_empty = 2'b11; st_pend = 2'b00; ins_vld = 2'b00;
        put_slots(7'h6A, 7'h00, 16'd600, 16'd601);
        @(negedge clk);
        #1;
        chk("R7 empty withheld by store commit", 32'(empty_rpt), 2);
        chk("R8 free_upd thread0 retire", 32'(free_upd), 1);

        // R7/R8: stores pending on thread 1, insert on thread 1
        grant_vld = 1'b0; rob_empty = 2'b11; st_pend = 2'b10; ins_vld = 2'b10;
        @(negedge clk);
        #1;
        chk("R7 empty withheld by pending stores", 32'(empty_rpt), 1);
        chk("R8 free_upd on insert", 32'(free_upd), 2);

        // R4/R5: squashed slot 0 then faulting slot 1
        grant_vld = 1'b1; grant_tid = 1'b0; rob_empty = '0; st_pend = '0; ins_vld = '0;
        put_slots(7'h70, 7'h6C, 16'd700, 16'd701);
        #1;
        chk("R4 trap after squashed head", 32'(trap_start), 1);
        chk("R2 squashed head removed", 32'(retire_mask), 1);
        @(negedge clk);
        put_slots(7'h68, 7'h68, 16'd800, 16'd801);
        #2;
        chk("R5 pend cycle1", 32'(trap_pend), 1);
        chk("R5 squash cycle1", 32'(trap_squash), 0);
        chk("R5 blocked cycle1", 32'(retire_mask), 0);
        @(negedge clk);
        #1;
        chk("R5 squash cycle2", 32'(trap_squash), 0);
        @(negedge clk);
        #1;
        chk("R5 squash cycle3", 32'(trap_squash), 1);
        chk("R5 trap_tid", 32'(trap_tid), 0);
        chk("R5 still blocked cycle3", 32'(retire_mask), 0);
        @(negedge clk);
        #1;
        chk("R5 pend cleared", 32'(trap_pend), 0);
        chk("R5 commit resumes", 32'(commit_mask), 3);
        @(negedge clk);
        grant_vld = 1'b0;
        #1;
        chk("R9 full_cnt after resume", 32'(full_cnt), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule